// File: doc/BRIEF.md
# Interrupt Pending and Trigger Logic

This block keeps the per-interrupt state that decides when an interrupt becomes pending for each processor. It holds enable bits, pending bits, the last sampled level of every external line, the trigger and handling-model configuration, and the processor target mask. Its inputs are the external interrupt lines and a simple register write port. The write port carries a register selector, a word index, byte enables, 32 data bits and the number of the requesting processor. Its outputs are flat per-processor enable and pending vectors, which a separate priority arbiter consumes. The arbiter also receives the handling-model bit of each interrupt.

Interrupt IDs below 32 are private to a processor. Their enable bits are banked per processor, and they have no external line. IDs from 32 upward are driven by external line n = ID − 32, and they share one enable bit across all processors. Pending bits are always kept separately for each processor. The write port has no back-pressure: a write presented with `wr_en` high is always taken at the next clock edge. Every state change shows on the outputs from the clock edge that samples the stimulus.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, every enable bit, pending bit, model bit, trigger bit, target mask and stored line level is 0.
- R2: On a rising edge of external line n (a 0→1 change of `irq_in[n]` relative to the level stored on the previous clock), interrupt 32+n becomes pending for each processor in its target mask. This happens only if the interrupt is configured edge-triggered or is enabled. The bit is visible the cycle after the edge is sampled.
- R3: A line that stays high, or that falls, sets no pending bit. A falling line only updates the stored level.
- R4: Configuration writes (selector 4) address word w. Byte lane k of that word covers IDs 16w+4k to 16w+4k+3. ID 16w+p uses data bits 2p+1:2p: bit 2p selects the one-of-N model (reported on `model_o`) and bit 2p+1 selects edge triggering. Writes that address IDs below 32 have no effect.
- R5: A set-enable write to a level-triggered interrupt (ID ≥ 32) whose stored line level is high also sets its pending bits for the target mask.
- R6: Set-enable (selector 0) and clear-enable (selector 1) use word w, bit b for ID 32w+b. For IDs below 32, only the requesting processor's bank changes. For IDs 32 and up, the change applies to all processors.
- R7: Set-pending (selector 2) uses the same bit layout as R6. For an ID of 32 or more it marks the target mask. For an ID below 32 it marks only the requesting processor.
- R8: Clear-pending (selector 3) uses the same bit layout and clears the bit for every processor.
- R9: Target writes (selector 5) address word w. Byte lane k sets the mask of ID 4w+k to the low NCPU bits of that byte. Only IDs 32 and up are stored.
- R10: A software-interrupt write (selector 6) needs all four byte enables. It takes the ID from data bits 9:0 and the filter from bits 25:24. Filter 0 targets the processor list in bits 23:16, filter 1 targets all processors except the requester, filter 2 targets the requester only, and filter 3 is dropped. An ID of NIRQ or above is dropped.
- R11: If a pending bit is both set and cleared in the same cycle, it ends up set.
- R12: For selectors 0–5, a byte lane whose byte enable is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NEXT (32) | External interrupt lines; line n is ID n+32 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (0 set-enable … 6 software interrupt) |
| wr_word | input | log2(NIRQ/4) (4) | Word index within the selected register |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| wr_cpu | input | max(1,log2 NCPU) (1) | Number of the requesting processor |
| enable_o | output | NCPU·NIRQ (128) | Enable bit of ID i for processor c at c·NIRQ+i |
| pending_o | output | NCPU·NIRQ (128) | Pending bit of ID i for processor c at c·NIRQ+i |
| model_o | output | NIRQ (64) | One-of-N model bit per ID (0 below 32) |

## Verification
The embedded assertions check three things on every cycle. A decoded set always leaves the pending bit high one cycle later, even against a simultaneous clear. A clear with no competing set empties the bit for every processor. Banked enables never move for a processor other than the requester, and shared enables clear for all processors together. The rules that combine several pieces of state can only be shown by the bench's scenarios, which compare against an independent model: edge versus level triggering, the enable-while-high case, target masks, the software filter codes, byte-lane masking and ignored configuration of private IDs.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

  localparam int PRIV_IDS = 32;

  typedef enum logic [2:0] {
    SEL_SET_EN  = 3'd0,
    SEL_CLR_EN  = 3'd1,
    SEL_SET_PD  = 3'd2,
    SEL_CLR_PD  = 3'd3,
    SEL_CFG     = 3'd4,
    SEL_TGT     = 3'd5,
    SEL_SOFT    = 3'd6,
    SEL_NONE    = 3'd7
  } wsel_e;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'd0,
    FLT_OTHERS = 2'd1,
    FLT_SELF   = 2'd2,
    FLT_DROP   = 2'd3
  } sgi_filt_e;

endpackage

// File: rtl/irq_pend_decode.sv
module irq_pend_decode
  import irq_pend_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NEXT = 32,
  parameter int NIRQ = PRIV_IDS + NEXT,
  parameter int WW   = 4,
  parameter int CW   = 1
) (
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [WW-1:0]        wr_word,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic [CW-1:0]        wr_cpu,
  output logic [NIRQ-1:0]      set_en_m,
  output logic [NIRQ-1:0]      clr_en_m,
  output logic [NIRQ-1:0]      set_pd_m,
  output logic [NIRQ-1:0]      clr_pd_m,
  output logic [NEXT-1:0]      cfg_we,
  output logic [2*NEXT-1:0]    cfg_val,
  output logic [NEXT-1:0]      tgt_we,
  output logic [NCPU*NEXT-1:0] tgt_val,
  output logic [NIRQ-1:0]      soft_hit,
  output logic [NCPU-1:0]      soft_mask
);

  wsel_e sel;
  assign sel = wsel_e'(wr_sel);

  // Bit-per-ID registers: word w, bit b -> ID 32w+b
  for (genvar i = 0; i < NIRQ; i++) begin : g_bit
    localparam int BW = i / 32;
    localparam int BB = i % 32;
    logic hit;
    assign hit = wr_en && (wr_word == WW'(BW)) && wr_be[BB/8] && wr_data[BB];
    assign set_en_m[i] = hit && (sel == SEL_SET_EN);
    assign clr_en_m[i] = hit && (sel == SEL_CLR_EN);
    assign set_pd_m[i] = hit && (sel == SEL_SET_PD);
    assign clr_pd_m[i] = hit && (sel == SEL_CLR_PD);
  end

  // Configuration (2 bits per ID) and target (1 byte per ID), external IDs only
  for (genvar j = 0; j < NEXT; j++) begin : g_ext
    localparam int ID  = j + PRIV_IDS;
    localparam int CWD = ID / 16;
    localparam int CF  = ID % 16;
    localparam int TWD = ID / 4;
    localparam int TL  = ID % 4;
    assign cfg_we[j]              = wr_en && (sel == SEL_CFG) &&
                                    (wr_word == WW'(CWD)) && wr_be[CF/4];
    assign cfg_val[2*j +: 2]      = wr_data[2*CF +: 2];
    assign tgt_we[j]              = wr_en && (sel == SEL_TGT) &&
                                    (wr_word == WW'(TWD)) && wr_be[TL];
    assign tgt_val[NCPU*j +: NCPU] = wr_data[8*TL +: NCPU];
  end

  // Software-generated interrupt decode
  logic            soft_go;
  logic [9:0]      soft_id;
  sgi_filt_e       filt;
  logic [NCPU-1:0] self_m;

  assign soft_go = wr_en && (sel == SEL_SOFT) && (&wr_be);
  assign soft_id = wr_data[9:0];
  assign filt    = sgi_filt_e'(wr_data[25:24]);
  assign self_m  = NCPU'(1) << wr_cpu;

  always_comb begin
    unique case (filt)
      FLT_LIST:   soft_mask = wr_data[16 +: NCPU];
      FLT_OTHERS: soft_mask = ~self_m;
      FLT_SELF:   soft_mask = self_m;
      default:    soft_mask = '0;
    endcase
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_soft
    assign soft_hit[i] = soft_go && (soft_id == 10'(i));
  end

endmodule

// File: rtl/irq_pend_cfg.sv
module irq_pend_cfg #(
  parameter int NCPU = 2,
  parameter int NEXT = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      irq_in,
  input  logic [NEXT-1:0]      cfg_we,
  input  logic [2*NEXT-1:0]    cfg_val,
  input  logic [NEXT-1:0]      tgt_we,
  input  logic [NCPU*NEXT-1:0] tgt_val,
  output logic [NEXT-1:0]      trig,
  output logic [NEXT-1:0]      model,
  output logic [NCPU*NEXT-1:0] tgt,
  output logic [NEXT-1:0]      lvl,
  output logic [NEXT-1:0]      rise
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= '0;
      trig  <= '0;
      model <= '0;
      tgt   <= '0;
    end else begin
      lvl <= irq_in;
      for (int j = 0; j < NEXT; j++) begin
        if (cfg_we[j]) begin
          model[j] <= cfg_val[2*j];
          trig[j]  <= cfg_val[2*j+1];
        end
        if (tgt_we[j]) tgt[NCPU*j +: NCPU] <= tgt_val[NCPU*j +: NCPU];
      end
    end
  end

  assign rise = irq_in & ~lvl;

endmodule

// File: rtl/irq_pend_enable.sv
module irq_pend_enable
  import irq_pend_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NEXT = 32,
  parameter int NIRQ = PRIV_IDS + NEXT,
  parameter int CW   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      set_en_m,
  input  logic [NIRQ-1:0]      clr_en_m,
  input  logic [CW-1:0]        wr_cpu,
  output logic [NCPU*NIRQ-1:0] en_o,
  output logic [NEXT-1:0]      en_sh
);

  for (genvar i = 0; i < NIRQ; i++) begin : g_id
    if (i < PRIV_IDS) begin : g_bank
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic b;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) b <= 1'b0;
          else if (wr_cpu == CW'(c)) begin
            if (set_en_m[i])      b <= 1'b1;
            else if (clr_en_m[i]) b <= 1'b0;
          end
        end
        assign en_o[c*NIRQ+i] = b;

        // R6
        bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
          ((set_en_m[i] || clr_en_m[i]) && wr_cpu != CW'(c)) |=> $stable(en_o[c*NIRQ+i]));
      end
    end else begin : g_shared
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           b <= 1'b0;
        else if (set_en_m[i]) b <= 1'b1;
        else if (clr_en_m[i]) b <= 1'b0;
      end
      assign en_sh[i-PRIV_IDS] = b;
      for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign en_o[c*NIRQ+i] = b;

        // R6
        shared_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (clr_en_m[i] && !set_en_m[i]) |=> !en_o[c*NIRQ+i]);
      end
    end
  end

endmodule

// File: rtl/irq_pend_bits.sv
module irq_pend_bits
  import irq_pend_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NEXT = 32,
  parameter int NIRQ = PRIV_IDS + NEXT,
  parameter int CW   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NIRQ-1:0]      set_pd_m,
  input  logic [NIRQ-1:0]      clr_pd_m,
  input  logic [NEXT-1:0]      set_en_ext,
  input  logic [NIRQ-1:0]      soft_hit,
  input  logic [NCPU-1:0]      soft_mask,
  input  logic [CW-1:0]        wr_cpu,
  input  logic [NEXT-1:0]      en_sh,
  input  logic [NEXT-1:0]      trig,
  input  logic [NEXT-1:0]      lvl,
  input  logic [NEXT-1:0]      rise,
  input  logic [NCPU*NEXT-1:0] tgt,
  output logic [NCPU*NIRQ-1:0] pd_o
);

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar i = 0; i < NIRQ; i++) begin : g_id
      logic set_v;
      if (i < PRIV_IDS) begin : g_priv
        assign set_v = (set_pd_m[i] && wr_cpu == CW'(c)) ||
                       (soft_hit[i] && soft_mask[c]);
      end else begin : g_ext
        localparam int J = i - PRIV_IDS;
        logic line_set, en_hi_set;
        assign line_set  = rise[J] && (trig[J] || en_sh[J]);
        assign en_hi_set = set_en_ext[J] && !trig[J] && lvl[J];
        assign set_v = (tgt[NCPU*J+c] && (line_set || set_pd_m[i] || en_hi_set)) ||
                       (soft_hit[i] && soft_mask[c]);
      end

      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b <= 1'b0;
        else        b <= (b && !clr_pd_m[i]) || set_v;
      end
      assign pd_o[c*NIRQ+i] = b;

      // R11
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |=> pd_o[c*NIRQ+i]);

      // R8
      clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pd_m[i] && !set_v) |=> !pd_o[c*NIRQ+i]);
    end
  end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NCPU = 2,
  parameter int NEXT = 32,
  localparam int NIRQ = PRIV_IDS + NEXT,
  localparam int WW   = $clog2(NIRQ / 4),
  localparam int CW   = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NEXT-1:0]      irq_in,
  input  logic                 wr_en,
  input  logic [2:0]           wr_sel,
  input  logic [WW-1:0]        wr_word,
  input  logic [3:0]           wr_be,
  input  logic [31:0]          wr_data,
  input  logic [CW-1:0]        wr_cpu,
  output logic [NCPU*NIRQ-1:0] enable_o,
  output logic [NCPU*NIRQ-1:0] pending_o,
  output logic [NIRQ-1:0]      model_o
);

  logic [NIRQ-1:0]      set_en_m, clr_en_m, set_pd_m, clr_pd_m, soft_hit;
  logic [NEXT-1:0]      cfg_we, tgt_we, trig, model, lvl, rise, en_sh;
  logic [2*NEXT-1:0]    cfg_val;
  logic [NCPU*NEXT-1:0] tgt_val, tgt;
  logic [NCPU-1:0]      soft_mask;

  irq_pend_decode #(.NCPU(NCPU), .NEXT(NEXT), .NIRQ(NIRQ), .WW(WW), .CW(CW)) u_dec (
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_word(wr_word), .wr_be(wr_be),
    .wr_data(wr_data), .wr_cpu(wr_cpu),
    .set_en_m(set_en_m), .clr_en_m(clr_en_m), .set_pd_m(set_pd_m), .clr_pd_m(clr_pd_m),
    .cfg_we(cfg_we), .cfg_val(cfg_val), .tgt_we(tgt_we), .tgt_val(tgt_val),
    .soft_hit(soft_hit), .soft_mask(soft_mask)
  );

  irq_pend_cfg #(.NCPU(NCPU), .NEXT(NEXT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .cfg_we(cfg_we), .cfg_val(cfg_val), .tgt_we(tgt_we), .tgt_val(tgt_val),
    .trig(trig), .model(model), .tgt(tgt), .lvl(lvl), .rise(rise)
  );

  irq_pend_enable #(.NCPU(NCPU), .NEXT(NEXT), .NIRQ(NIRQ), .CW(CW)) u_en (
    .clk(clk), .rst_n(rst_n), .set_en_m(set_en_m), .clr_en_m(clr_en_m),
    .wr_cpu(wr_cpu), .en_o(enable_o), .en_sh(en_sh)
  );

  irq_pend_bits #(.NCPU(NCPU), .NEXT(NEXT), .NIRQ(NIRQ), .CW(CW)) u_pd (
    .clk(clk), .rst_n(rst_n), .set_pd_m(set_pd_m), .clr_pd_m(clr_pd_m),
    .set_en_ext(set_en_m[NIRQ-1:PRIV_IDS]), .soft_hit(soft_hit), .soft_mask(soft_mask),
    .wr_cpu(wr_cpu), .en_sh(en_sh), .trig(trig), .lvl(lvl), .rise(rise), .tgt(tgt),
    .pd_o(pending_o)
  );

  assign model_o = {model, {PRIV_IDS{1'b0}}};

endmodule

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;

  localparam int PERIOD = 10;
  localparam int NCPU   = 2;
  localparam int NEXT   = 32;
  localparam int NIRQ   = 32 + NEXT;
  localparam int WW     = $clog2(NIRQ / 4);
  localparam int CW     = 1;
  localparam int VW     = NCPU * NIRQ;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NEXT-1:0] d_irq = '0;
  logic            d_en = 1'b0;
  logic [2:0]      d_sel = '0;
  logic [WW-1:0]   d_word = '0;
  logic [3:0]      d_be = '0;
  logic [31:0]     d_data = '0;
  logic [CW-1:0]   d_cpu = '0;
  logic [VW-1:0]   enable_o, pending_o;
  logic [NIRQ-1:0] model_o;

  irq_pend_ctrl #(.NCPU(NCPU), .NEXT(NEXT)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(d_irq), .wr_en(d_en), .wr_sel(d_sel),
    .wr_word(d_word), .wr_be(d_be), .wr_data(d_data), .wr_cpu(d_cpu),
    .enable_o(enable_o), .pending_o(pending_o), .model_o(model_o)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    string           tag;
    logic [VW-1:0]   pd;
    logic [VW-1:0]   en;
    logic [NIRQ-1:0] md;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // Reference state built from the requirements
  logic [VW-1:0]   m_en = '0, m_pd = '0;
  logic [NIRQ-1:0] m_model = '0, m_trig = '0, m_lvl = '0;
  logic [NCPU-1:0] m_tgt [NIRQ];

  task automatic check(input string tag, input string what,
                       input logic [VW-1:0] got, input logic [VW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Driver side: advance the reference by one cycle of the current stimulus
  task automatic cycle(input string tag);
    logic [VW-1:0]   s_v;
    logic [NIRQ-1:0] c_v;
    logic [NCPU-1:0] sm, self_m;
    logic            go;
    exp_t            e;
    self_m = NCPU'(1) << d_cpu;
    go = d_en && d_sel == 3'd6 && d_be == 4'hF;
    case (d_data[25:24])
      2'd0:    sm = d_data[16 +: NCPU];
      2'd1:    sm = ~self_m;
      2'd2:    sm = self_m;
      default: sm = '0;
    endcase
    s_v = '0;
    c_v = '0;
    for (int i = 0; i < NIRQ; i++) begin
      logic bh, any, r;
      bh = d_en && d_word == WW'(i/32) && d_be[(i%32)/8] && d_data[i%32];
      c_v[i] = bh && d_sel == 3'd3;
      any = 1'b0;
      for (int c = 0; c < NCPU; c++) any |= m_en[c*NIRQ+i];
      r = 1'b0;
      if (i >= 32) r = d_irq[i-32] && !m_lvl[i];
      for (int c = 0; c < NCPU; c++) begin
        if (go && d_data[9:0] == 10'(i) && sm[c]) s_v[c*NIRQ+i] = 1'b1;
        if (i < 32) begin
          if (bh && d_sel == 3'd2 && d_cpu == CW'(c)) s_v[c*NIRQ+i] = 1'b1;
        end else if (m_tgt[i][c] &&
                     ((r && (m_trig[i] || any)) || (bh && d_sel == 3'd2) ||
                      (bh && d_sel == 3'd0 && !m_trig[i] && m_lvl[i])))
          s_v[c*NIRQ+i] = 1'b1;
      end
      if (bh && (d_sel == 3'd0 || d_sel == 3'd1)) begin
        for (int c = 0; c < NCPU; c++)
          if (i >= 32 || d_cpu == CW'(c)) m_en[c*NIRQ+i] = (d_sel == 3'd0);
      end
      if (i >= 32 && d_en && d_sel == 3'd4 && d_word == WW'(i/16) && d_be[(i%16)/4]) begin
        m_model[i] = d_data[2*(i%16)];
        m_trig[i]  = d_data[2*(i%16)+1];
      end
      if (i >= 32 && d_en && d_sel == 3'd5 && d_word == WW'(i/4) && d_be[i%4])
        m_tgt[i] = d_data[8*(i%4) +: NCPU];
      if (i >= 32) m_lvl[i] = d_irq[i-32];
    end
    for (int c = 0; c < NCPU; c++)
      m_pd[c*NIRQ +: NIRQ] = (m_pd[c*NIRQ +: NIRQ] & ~c_v) | s_v[c*NIRQ +: NIRQ];
    e.tag = tag; e.pd = m_pd; e.en = m_en; e.md = m_model;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input int word, input logic [3:0] be,
                    input logic [31:0] data, input int cpu, input string tag);
    d_en = 1'b1; d_sel = sel; d_word = WW'(word); d_be = be; d_data = data; d_cpu = CW'(cpu);
    cycle(tag);
    d_en = 1'b0;
  endtask

  task automatic line(input int n, input logic v, input string tag);
    d_irq[n] = v;
    cycle(tag);
  endtask

  // Monitor: compare one expectation per cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "pending", pending_o, e.pd);
      check(e.tag, "enable", enable_o, e.en);
      check(e.tag, "model", VW'(model_o), VW'(e.md));
    end
  end

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL R1 watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) m_tgt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycle("R1");                                  // reset state

    // R4: ID32 edge, ID33 model; private config ignored
    wr(3'd4, 2, 4'b0001, 32'h0000_0006, 0, "R4");
    wr(3'd4, 0, 4'hF, 32'hFFFF_FFFF, 0, "R4");
    // R12: lane disabled, nothing changes
    wr(3'd4, 2, 4'b1110, 32'h0000_00FF, 0, "R12");
    // R9: targets ID32=3, ID33=2, ID34=1, ID35=3
    wr(3'd5, 8, 4'hF, 32'h0301_0203, 0, "R9");

    // R2: edge-triggered rising line 0
    line(0, 1'b1, "R2");
    line(0, 1'b1, "R3");                          // held high
    line(0, 1'b0, "R3");                          // falling
    wr(3'd3, 1, 4'hF, 32'h0000_0001, 1, "R8");    // clears both CPUs

    // R3: disabled level line rising gives nothing
    line(1, 1'b1, "R3");
    // R5 / R6: enable ID33 while high, target CPU1 only
    wr(3'd0, 1, 4'hF, 32'h0000_0002, 0, "R5");

    // R11: edge and clear-pending on ID32 in one cycle
    d_irq[0] = 1'b1;
    wr(3'd3, 1, 4'hF, 32'h0000_0001, 0, "R11");

    // R6: banked enable for ID5
    wr(3'd0, 0, 4'hF, 32'h0000_0020, 1, "R6");
    wr(3'd1, 0, 4'hF, 32'h0000_0020, 0, "R6");
    wr(3'd1, 0, 4'hF, 32'h0000_0020, 1, "R6");
    wr(3'd1, 1, 4'hF, 32'h0000_0002, 0, "R6");    // shared clear

    // R7: private ID3 from CPU0, external ID34 via target
    wr(3'd2, 0, 4'hF, 32'h0000_0008, 0, "R7");
    wr(3'd2, 1, 4'hF, 32'h0000_0004, 1, "R7");
    // R12: lane 0 masked
    wr(3'd2, 0, 4'b1110, 32'h0000_00F0, 0, "R12");

    // R10: software interrupts
    wr(3'd6, 0, 4'hF, 32'h0002_0007, 0, "R10");
    wr(3'd6, 0, 4'hF, 32'h0100_0008, 0, "R10");
    wr(3'd6, 0, 4'hF, 32'h0200_0009, 1, "R10");
    wr(3'd6, 0, 4'hF, 32'h0300_000A, 0, "R10");
    wr(3'd6, 0, 4'hF, 32'h0200_0064, 0, "R10");
    wr(3'd6, 0, 4'b0111, 32'h0200_000B, 0, "R10");

    // R2: enabled level line pends on rise
    wr(3'd0, 1, 4'hF, 32'h0000_0008, 0, "R2");
    line(3, 1'b1, "R2");
    wr(3'd3, 1, 4'hF, 32'hFFFF_FFFF, 0, "R8");
    wr(3'd3, 0, 4'hF, 32'hFFFF_FFFF, 1, "R8");
    cycle("R3");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule